// File: doc/BRIEF.md
# Microprogram Sequencer with Jump-Type Next-State Selection

This block is the control unit of a bus-based processor that runs one microinstruction per clock. It keeps a micro-program counter (`upc`), reads a 20-bit word from a built-in control store at that address, and drives the 17 datapath control lines held in that word. The three remaining bits are a jump code. They tell the sequencer where to go next: one step forward, stay put while memory is busy, back to the fetch routine, a routine picked by the current opcode, or a conditional return to fetch based on the zero flag.

The control store holds a shared four-step fetch routine and one routine for each instruction group: register ALU, ALU-immediate, load, store, BEQZ, BNEZ, J, JR, JAL and JALR. The datapath around the block supplies the opcode (the top six bits of the instruction register), the zero flag from register A, and the busy flag from the slow memory. The micro-PC is also a port, so the running routine can be observed.

Top module: `microseq`

## Requirements
- R1: When `rst_n` is low, `upc` is 0 at once (asynchronous reset). While `upc` is 0, `ctrl` carries the MA←PC word.
- R2: Jump code next (0) moves `upc` to `upc`+1 at the next rising clock edge.
- R3: Jump code spin (1) keeps `upc` unchanged while `busy` is 1. It moves to `upc`+1 on the first edge where `busy` is 0.
- R4: Jump code fetch (2), and the unused codes 6 and 7, load `upc` with 0, the start of the fetch routine.
- R5: Jump code dispatch (3) loads `upc` with the start address of the opcode's group. The mapping is: opcode 0x00 → 4 (ALU); 0x08–0x0F → 7 (ALU-immediate); 0x23 → 10 (load); 0x2B → 15 (store); 0x04 → 20 (BEQZ); 0x05 → 25 (BNEZ); 0x02 → 30 (J); 0x06 → 33 (JR); 0x03 → 35 (JAL); 0x07 → 39 (JALR).
- R6: Jump code feqz (4) goes to 0 when `zero` is 1 and to `upc`+1 otherwise. Jump code fnez (5) goes to 0 when `zero` is 0 and to `upc`+1 otherwise.
- R7: The `ctrl` bits are laid out as follows.
  - Load enables: [16] IR, [15] A, [14] B, [13] MA, [12] PC.
  - [11] register write.
  - [10:9] register select: 0 rs, 1 rt, 2 rd, 3 link register 31.
  - [8:6] bus source: 0 none, 1 PC, 2 register file, 3 immediate, 4 ALU, 5 memory, 6 IR.
  - [5:4] immediate form: 0 sign-extended, 1 sign-extended shifted left by 2.
  - [3:1] ALU function: 0 pass A, 1 A+4, 2 A+B, 3 func(A,B), 4 op(A,B), 5 jump target, 6 pass B.
  - [0] memory write.
- R8: The fetch routine is at addresses 0–3 and runs MA←PC (next), IR←memory (spin), A←PC (next), PC←A+4 (dispatch).
- R9: A load runs A←rs, B←sext(imm), MA←A+B, rt←memory (spin), then an idle word that jumps to fetch. A store runs the same steps, but its memory step drives rt onto the bus with memory write set. Memory write is set in no other step.
- R10: BEQZ runs A←rs and then a step with fnez. BNEZ does the same with feqz. When the branch is taken, both continue with A←PC, B←sext(imm)<<2, PC←A+B and then return to fetch.
- R11: JAL runs A←PC, reg31←A, B←IR, PC←jump target. JALR runs A←PC, B←rs, reg31←A, PC←B. J runs A←PC, B←IR, PC←jump target. JR runs A←rs, PC←A.
- R12: An opcode not listed in R5 dispatches to 0, the fetch routine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | Register A equals zero |
| busy | input | 1 | Memory access still in progress |
| ctrl | output | 17 | Datapath control lines of the current microinstruction |
| upc | output | 6 | Current micro-program counter |

## Verification
The embedded assertions check the jump rules on every cycle:
- increment after next;
- hold or advance after spin, depending on busy;
- return to address 0 after fetch;
- conditional return after feqz and fnez.

Only the directed scenarios can show the rest:
- that each routine's control words carry the right fields in the right order;
- that each opcode dispatches to its own group start, and that unlisted opcodes fall back to fetch;
- that branches are taken or fall through on the correct zero polarity;
- that the link write comes at the right step in JAL and JALR.

// File: rtl/microseq.sv
module microseq #(
  parameter int OP_W  = 6,
  parameter int UPC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opcode,
  input  logic             zero,
  input  logic             busy,
  output logic [16:0]      ctrl,
  output logic [UPC_W-1:0] upc
);
  localparam int CTRL_W = 17;
  localparam int JT_W   = 3;
  localparam int WORD_W = CTRL_W + JT_W;
  localparam logic [UPC_W-1:0] FETCH_PC = '0;

  localparam logic [2:0] J_NEXT = 3'd0, J_SPIN = 3'd1, J_FETCH = 3'd2,
                         J_DISP = 3'd3, J_FEQZ = 3'd4, J_FNEZ = 3'd5;
  localparam logic [4:0] L_NO = 5'b00000, L_IR = 5'b10000, L_A = 5'b01000,
                         L_B = 5'b00100, L_MA = 5'b00010, L_PC = 5'b00001;
  localparam logic [1:0] R_RS = 2'd0, R_RT = 2'd1, R_RD = 2'd2, R_LNK = 2'd3;
  localparam logic [2:0] S_NO = 3'd0, S_PC = 3'd1, S_REG = 3'd2, S_IMM = 3'd3,
                         S_ALU = 3'd4, S_MEM = 3'd5, S_IR = 3'd6;
  localparam logic [1:0] I_SX = 2'd0, I_SX2 = 2'd1;
  localparam logic [2:0] F_A = 3'd0, F_A4 = 3'd1, F_ADD = 3'd2, F_FUNC = 3'd3,
                         F_OPI = 3'd4, F_JT = 3'd5, F_B = 3'd6;

  function automatic logic [WORD_W-1:0] uw(
    input logic [2:0] jt, input logic [4:0] ld, input logic rw,
    input logic [1:0] rsel, input logic [2:0] src, input logic [1:0] im,
    input logic [2:0] fn, input logic mw);
    return {jt, ld, rw, rsel, src, im, fn, mw};
  endfunction

  function automatic logic [WORD_W-1:0] rom(input logic [UPC_W-1:0] a);
    case (int'(a))
      0:                      return uw(J_NEXT,  L_MA, 1'b0, R_RS,  S_PC,  I_SX,  F_A,    1'b0);
      1:                      return uw(J_SPIN,  L_IR, 1'b0, R_RS,  S_MEM, I_SX,  F_A,    1'b0);
      2, 22, 27, 30, 35, 39:  return uw(J_NEXT,  L_A,  1'b0, R_RS,  S_PC,  I_SX,  F_A,    1'b0);
      3:                      return uw(J_DISP,  L_PC, 1'b0, R_RS,  S_ALU, I_SX,  F_A4,   1'b0);
      4, 7, 10, 15, 20, 25, 33:
                              return uw(J_NEXT,  L_A,  1'b0, R_RS,  S_REG, I_SX,  F_A,    1'b0);
      5:                      return uw(J_NEXT,  L_B,  1'b0, R_RT,  S_REG, I_SX,  F_A,    1'b0);
      6:                      return uw(J_FETCH, L_NO, 1'b1, R_RD,  S_ALU, I_SX,  F_FUNC, 1'b0);
      8, 11, 16:              return uw(J_NEXT,  L_B,  1'b0, R_RS,  S_IMM, I_SX,  F_A,    1'b0);
      9:                      return uw(J_FETCH, L_NO, 1'b1, R_RT,  S_ALU, I_SX,  F_OPI,  1'b0);
      12, 17:                 return uw(J_NEXT,  L_MA, 1'b0, R_RS,  S_ALU, I_SX,  F_ADD,  1'b0);
      13:                     return uw(J_SPIN,  L_NO, 1'b1, R_RT,  S_MEM, I_SX,  F_A,    1'b0);
      18:                     return uw(J_SPIN,  L_NO, 1'b0, R_RT,  S_REG, I_SX,  F_A,    1'b1);
      21:                     return uw(J_FNEZ,  L_NO, 1'b0, R_RS,  S_NO,  I_SX,  F_A,    1'b0);
      26:                     return uw(J_FEQZ,  L_NO, 1'b0, R_RS,  S_NO,  I_SX,  F_A,    1'b0);
      23, 28:                 return uw(J_NEXT,  L_B,  1'b0, R_RS,  S_IMM, I_SX2, F_A,    1'b0);
      24, 29:                 return uw(J_FETCH, L_PC, 1'b0, R_RS,  S_ALU, I_SX,  F_ADD,  1'b0);
      31, 37:                 return uw(J_NEXT,  L_B,  1'b0, R_RS,  S_IR,  I_SX,  F_A,    1'b0);
      32, 38:                 return uw(J_FETCH, L_PC, 1'b0, R_RS,  S_ALU, I_SX,  F_JT,   1'b0);
      34:                     return uw(J_FETCH, L_PC, 1'b0, R_RS,  S_ALU, I_SX,  F_A,    1'b0);
      36, 41:                 return uw(J_NEXT,  L_NO, 1'b1, R_LNK, S_ALU, I_SX,  F_A,    1'b0);
      40:                     return uw(J_NEXT,  L_B,  1'b0, R_RS,  S_REG, I_SX,  F_A,    1'b0);
      42:                     return uw(J_FETCH, L_PC, 1'b0, R_RS,  S_ALU, I_SX,  F_B,    1'b0);
      default:                return uw(J_FETCH, L_NO, 1'b0, R_RS,  S_NO,  I_SX,  F_A,    1'b0);
    endcase
  endfunction

  function automatic logic [UPC_W-1:0] dispatch(input logic [OP_W-1:0] op);
    if (op[OP_W-1:3] == 3'b001) return UPC_W'(7);
    case (op)
      6'h00:   return UPC_W'(4);
      6'h23:   return UPC_W'(10);
      6'h2B:   return UPC_W'(15);
      6'h04:   return UPC_W'(20);
      6'h05:   return UPC_W'(25);
      6'h02:   return UPC_W'(30);
      6'h06:   return UPC_W'(33);
      6'h03:   return UPC_W'(35);
      6'h07:   return UPC_W'(39);
      default: return FETCH_PC;
    endcase
  endfunction

  logic [WORD_W-1:0] word;
  logic [JT_W-1:0]   jt;
  logic [UPC_W-1:0]  upc_inc, upc_nxt;

  assign word    = rom(upc);
  assign jt      = word[WORD_W-1 -: JT_W];
  assign ctrl    = word[CTRL_W-1:0];
  assign upc_inc = upc + UPC_W'(1);

  always_comb begin
    case (jt)
      J_NEXT:  upc_nxt = upc_inc;
      J_SPIN:  upc_nxt = busy ? upc : upc_inc;
      J_DISP:  upc_nxt = dispatch(opcode);
      J_FEQZ:  upc_nxt = zero ? FETCH_PC : upc_inc;
      J_FNEZ:  upc_nxt = zero ? upc_inc : FETCH_PC;
      default: upc_nxt = FETCH_PC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) upc <= FETCH_PC;
    else        upc <= upc_nxt;

  assert_next_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    jt == J_NEXT |=> upc == $past(upc) + UPC_W'(1));

  assert_spin_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_SPIN && busy) |=> $stable(upc));

  assert_spin_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_SPIN && !busy) |=> upc == $past(upc) + UPC_W'(1));

  assert_fetch_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (jt == J_FETCH || jt > J_FNEZ) |=> upc == FETCH_PC);

  assert_cond_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((jt == J_FEQZ && zero) || (jt == J_FNEZ && !zero)) |=> upc == FETCH_PC);

  assert_cond_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((jt == J_FEQZ && !zero) || (jt == J_FNEZ && zero)) |=> upc == $past(upc) + UPC_W'(1));
endmodule

// File: tb/test_microseq.sv
module test_microseq;
  logic clk = 1'b0, rst_n = 1'b0, zero = 1'b0, busy = 1'b0;
  logic [5:0] opcode = '0;
  logic [16:0] ctrl;
  logic [5:0] upc;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  microseq i_microseq (.clk(clk), .rst_n(rst_n), .opcode(opcode), .zero(zero),
                       .busy(busy), .ctrl(ctrl), .upc(upc));

  function automatic logic [16:0] cw(input logic [4:0] ld, input logic rw,
    input logic [1:0] rsel, input logic [2:0] src, input logic [1:0] im,
    input logic [2:0] fn, input logic mw);
    return {ld, rw, rsel, src, im, fn, mw};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic exu(input int u, input string req);
    chk(upc == u, req, upc, u);
  endtask

  task automatic ex(input int u, input logic [16:0] c, input string req);
    chk(upc == u, req, upc, u);
    chk(ctrl == c, req, ctrl, c);
  endtask

  task automatic do_fetch(input logic [5:0] op, input int nbusy);
    ex(0, cw(5'b00010, 0, 0, 1, 0, 0, 0), "R8");
    step();
    ex(1, cw(5'b10000, 0, 0, 5, 0, 0, 0), "R8");
    if (nbusy > 0) busy = 1'b1;
    for (int i = 0; i < nbusy; i++) begin
      step();
      exu(1, "R3");
    end
    busy = 1'b0;
    step();
    ex(2, cw(5'b01000, 0, 0, 1, 0, 0, 0), "R2");
    step();
    ex(3, cw(5'b00001, 0, 0, 4, 0, 1, 0), "R8");
    opcode = op;
    step();
  endtask

  task automatic t_reset();
    exu(0, "R1");
    chk(ctrl == cw(5'b00010, 0, 0, 1, 0, 0, 0), "R1", ctrl, cw(5'b00010, 0, 0, 1, 0, 0, 0));
    step(); step();
    exu(2, "R2");
    rst_n = 1'b0;
    #1;
    exu(0, "R1");
    step();
    exu(0, "R1");
    rst_n = 1'b1;
  endtask

  task automatic t_alu();
    do_fetch(6'h00, 0);
    ex(4, cw(5'b01000, 0, 0, 2, 0, 0, 0), "R5");
    step(); ex(5, cw(5'b00100, 0, 1, 2, 0, 0, 0), "R2");
    step(); ex(6, cw(5'b00000, 1, 2, 4, 0, 3, 0), "R7");
    step(); exu(0, "R4");
  endtask

  task automatic t_alui();
    do_fetch(6'h0C, 1);
    exu(7, "R5");
    step(); ex(8, cw(5'b00100, 0, 0, 3, 0, 0, 0), "R7");
    step(); ex(9, cw(5'b00000, 1, 1, 4, 0, 4, 0), "R7");
    step(); exu(0, "R4");
  endtask

  task automatic t_load();
    do_fetch(6'h23, 3);
    exu(10, "R5");
    step(); exu(11, "R9");
    step(); ex(12, cw(5'b00010, 0, 0, 4, 0, 2, 0), "R9");
    busy = 1'b1;
    step(); ex(13, cw(5'b00000, 1, 1, 5, 0, 0, 0), "R9");
    step(); exu(13, "R3");
    busy = 1'b0;
    step(); ex(14, '0, "R9");
    step(); exu(0, "R4");
  endtask

  task automatic t_store();
    do_fetch(6'h2B, 0);
    exu(15, "R5");
    step(); step();
    ex(17, cw(5'b00010, 0, 0, 4, 0, 2, 0), "R9");
    step(); ex(18, cw(5'b00000, 0, 1, 2, 0, 0, 1), "R9");
    step(); ex(19, '0, "R9");
    step(); exu(0, "R4");
  endtask

  task automatic t_beqz(input logic z);
    zero = z;
    do_fetch(6'h04, 0);
    exu(20, "R5");
    step(); exu(21, "R10");
    step();
    if (!z) exu(0, "R6");
    else begin
      ex(22, cw(5'b01000, 0, 0, 1, 0, 0, 0), "R10");
      step(); ex(23, cw(5'b00100, 0, 0, 3, 1, 0, 0), "R10");
      step(); ex(24, cw(5'b00001, 0, 0, 4, 0, 2, 0), "R10");
      step(); exu(0, "R4");
    end
    zero = 1'b0;
  endtask

  task automatic t_bnez(input logic z);
    zero = z;
    do_fetch(6'h05, 0);
    exu(25, "R5");
    step(); exu(26, "R10");
    step();
    if (z) exu(0, "R6");
    else begin
      exu(27, "R6");
      step(); ex(28, cw(5'b00100, 0, 0, 3, 1, 0, 0), "R10");
      step(); exu(29, "R10");
      step(); exu(0, "R4");
    end
    zero = 1'b0;
  endtask

  task automatic t_jumps();
    do_fetch(6'h02, 0);
    exu(30, "R5");
    step(); ex(31, cw(5'b00100, 0, 0, 6, 0, 0, 0), "R11");
    step(); ex(32, cw(5'b00001, 0, 0, 4, 0, 5, 0), "R11");
    step(); exu(0, "R4");
    do_fetch(6'h06, 0);
    exu(33, "R5");
    step(); ex(34, cw(5'b00001, 0, 0, 4, 0, 0, 0), "R11");
    step(); exu(0, "R4");
  endtask

  task automatic t_links();
    do_fetch(6'h03, 0);
    ex(35, cw(5'b01000, 0, 0, 1, 0, 0, 0), "R11");
    step(); ex(36, cw(5'b00000, 1, 3, 4, 0, 0, 0), "R11");
    step(); ex(37, cw(5'b00100, 0, 0, 6, 0, 0, 0), "R11");
    step(); ex(38, cw(5'b00001, 0, 0, 4, 0, 5, 0), "R11");
    step(); exu(0, "R4");
    do_fetch(6'h07, 0);
    exu(39, "R5");
    step(); ex(40, cw(5'b00100, 0, 0, 2, 0, 0, 0), "R11");
    step(); ex(41, cw(5'b00000, 1, 3, 4, 0, 0, 0), "R11");
    step(); ex(42, cw(5'b00001, 0, 0, 4, 0, 6, 0), "R11");
    step(); exu(0, "R4");
  endtask

  task automatic t_unknown();
    do_fetch(6'h3F, 0);
    exu(0, "R12");
    do_fetch(6'h01, 0);
    exu(0, "R12");
    do_fetch(6'h0F, 0);
    exu(7, "R5");
    step(); step(); step();
    exu(0, "R4");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alu();
    t_alui();
    t_load();
    t_store();
    t_beqz(1'b1);
    t_beqz(1'b0);
    t_bnez(1'b0);
    t_bnez(1'b1);
    t_jumps();
    t_links();
    t_unknown();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", upc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule